// File: doc/BRIEF.md
# Daisy-Chained Expansion Bus Arbiter

This block is the expansion-bus control for one repeater device in a chain of up to seven. The devices share the bus without a central arbiter: each one passes an active-low select signal downstream, and the device at the head of the active chain pulls a wired acknowledge line low. Any device that can see activity both locally and upstream, or on two upstream branches at once, pulls a wired collision line low. The device holding acknowledge drives a shared JAM/DAT pair. JAM carries the local collision flag. DAT carries NRZ data, or, during a collision, whether that collision involves one port or several. A device that is idle while acknowledge is asserted listens to the pair instead of driving it.

A strap read after reset chooses the mode. In internal-arbitration mode the device takes part in the daisy chain. In external mode an outside arbiter owns acknowledge and collision, and the select output only reports local activity. The bus inputs are registered on every system clock. The bus outputs change only at bit-time boundaries, once every `CLK_PER_BIT` clocks. The open-drain lines leave the block as a pull-down enable, and the wired-AND resolution is done outside it.

Top module: `xbus_arbiter`

## Requirements
- R1: After reset, `sel_out_n` is 1 and `ack_oe`, `col_oe`, `bus_oe`, `jam_out`, `dat_out`, `rx_valid`, `rx_jam`, `rx_dat` and `coll_seen` are all 0.
- R2: The value of `sel_in_n[0]` at the first clock edge after reset release sets the mode: 1 selects internal arbitration (`arb_internal`=1), 0 selects external mode (`arb_internal`=0). The mode then holds until the next reset.
- R3: In internal mode, `sel_out_n` is 0 when the local device is active or when any `sel_in_n` bit is 0. Otherwise it is 1.
- R4: In internal mode, `ack_oe` is 1 exactly when the local device is active and all `sel_in_n` bits are 1.
- R5: In internal mode, `col_oe` is 1 when the local device is active and some `sel_in_n` bit is 0, or when two or more `sel_in_n` bits are 0.
- R6: In external mode, `ack_oe` and `col_oe` stay 0 and `sel_out_n` equals the inverse of local activity, whatever the select inputs are.
- R7: `bus_oe` is 1 when the acknowledge line was low and the device was active. `jam_out` then equals the local collision flag. `dat_out` is 1 for a single-port collision, 0 for a multiport collision (`local_multi`=1), and `tx_bit` when there is no collision. When `bus_oe` is 0, `jam_out` and `dat_out` are 0.
- R8: `rx_valid` is 1 when the acknowledge line was low and the device was idle. `rx_jam` and `rx_dat` then follow the sampled `jam_in` and `dat_in`; otherwise they are 0.
- R9: `coll_seen` is 1 when the sampled collision line was low.
- R10: Inputs are registered on every clock. Outputs update only on the bit tick, which is the last of each group of `CLK_PER_BIT` clocks counted from reset release. A tick uses the inputs registered one clock earlier, and the outputs hold for the rest of the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_in_n | input | NSEL | Active-low select inputs from upstream devices; bit 0 is also the mode strap |
| local_active | input | 1 | Local ports are receiving, colliding, draining the FIFO or extending a fragment |
| local_col | input | 1 | Collision on one or more local ports |
| local_multi | input | 1 | The local collision involves more than one port |
| tx_bit | input | 1 | NRZ data bit to place on DAT |
| ack_n_in | input | 1 | Resolved acknowledge line (active low) |
| col_n_in | input | 1 | Resolved collision line (active low) |
| jam_in | input | 1 | Resolved JAM line |
| dat_in | input | 1 | Resolved DAT line |
| sel_out_n | output | 1 | Active-low select to downstream devices |
| ack_oe | output | 1 | Pull the acknowledge line low |
| col_oe | output | 1 | Pull the collision line low |
| bus_oe | output | 1 | Drive enable for JAM and DAT |
| jam_out | output | 1 | JAM drive value |
| dat_out | output | 1 | DAT drive value |
| rx_valid | output | 1 | JAM/DAT are being received from another device |
| rx_jam | output | 1 | Received JAM |
| rx_dat | output | 1 | Received DAT |
| coll_seen | output | 1 | Multi-device collision seen on the bus |
| arb_internal | output | 1 | 1 when internal arbitration was strapped |

## Verification
A wrong select or collision equation appears at `sel_out_n`, `ack_oe` or `col_oe` at the first bit tick after the offending input pattern, so it is visible within two clocks. A bad bit-tick phase shows up as an output that moves in the middle of a bit, and a mid-bit comparison catches it one clock later. Because acknowledge feeds back into the bus drive, a wrong bus-drive or receive decision shows on `bus_oe`, `jam_out`, `dat_out` or the `rx_*` outputs at the tick after acknowledge was resolved. A mis-captured strap shows on `arb_internal`, and on the suppressed open-drain outputs, from the first tick after reset.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef struct packed {
        logic active;
        logic col;
        logic multi;
        logic txd;
        logic ack_n;
        logic col_n;
        logic jam;
        logic dat;
    } bus_smp_t;

    typedef struct packed {
        logic sel_out_n;
        logic ack_oe;
        logic col_oe;
        logic bus_oe;
        logic jam_out;
        logic dat_out;
        logic rx_valid;
        logic rx_jam;
        logic rx_dat;
        logic coll_seen;
    } bus_out_t;

    localparam bus_smp_t SMP_IDLE = '{ack_n: 1'b1, col_n: 1'b1, default: 1'b0};
    localparam bus_out_t OUT_IDLE = '{sel_out_n: 1'b1, default: 1'b0};

endpackage

// File: rtl/xbus_bit_timer.sv
module xbus_bit_timer #(
    parameter int CLK_PER_BIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/xbus_strap.sv
module xbus_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_pin,
    output logic internal
);
    typedef struct packed {
        logic done;
        logic intl;
    } strap_t;

    strap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.done = 1'b1;
            st_d.intl = strap_pin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{done: 1'b0, intl: 1'b1};
        else        st_q <= st_d;
    end

    assign internal = st_q.intl;

    // R2: once captured, the mode never moves
    a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> $stable(st_q.intl));
endmodule

// File: rtl/xbus_sampler.sv
module xbus_sampler
    import xbus_pkg::*;
#(
    parameter int NSEL = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSEL-1:0] sel_in_n,
    input  bus_smp_t        raw,
    output logic [NSEL-1:0] sel_s,
    output bus_smp_t        smp
);
    logic [NSEL-1:0] sel_d, sel_q;
    bus_smp_t        smp_d, smp_q;

    always_comb begin
        sel_d = sel_in_n;
        smp_d = raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '1;
            smp_q <= SMP_IDLE;
        end else begin
            sel_q <= sel_d;
            smp_q <= smp_d;
        end
    end

    assign sel_s = sel_q;
    assign smp   = smp_q;
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int NSEL = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            internal,
    input  logic [NSEL-1:0] sel_s,
    input  bus_smp_t        smp,
    output bus_out_t        out
);
    localparam int CW = $clog2(NSEL + 1);

    bus_out_t        out_d, out_q;
    logic [CW-1:0]   nlow;
    logic            any_low;
    logic            multi_low;
    logic            ack_low;

    always_comb begin
        nlow = '0;
        for (int i = 0; i < NSEL; i++) begin
            nlow = nlow + CW'(!sel_s[i]);
        end
        any_low   = (nlow != '0);
        multi_low = (nlow > CW'(1));
        ack_low   = !smp.ack_n;

        out_d = out_q;
        if (tick) begin
            if (internal) begin
                out_d.sel_out_n = !(smp.active || any_low);
                out_d.ack_oe    = smp.active && !any_low;
                out_d.col_oe    = (smp.active && any_low) || multi_low;
            end else begin
                out_d.sel_out_n = !smp.active;
                out_d.ack_oe    = 1'b0;
                out_d.col_oe    = 1'b0;
            end
            out_d.bus_oe    = smp.active && ack_low;
            out_d.jam_out   = out_d.bus_oe && smp.col;
            out_d.dat_out   = out_d.bus_oe && (smp.col ? !smp.multi : smp.txd);
            out_d.rx_valid  = ack_low && !smp.active;
            out_d.rx_jam    = out_d.rx_valid && smp.jam;
            out_d.rx_dat    = out_d.rx_valid && smp.dat;
            out_d.coll_seen = !smp.col_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= OUT_IDLE;
        else        out_q <= out_d;
    end

    assign out = out_q;

    // R10: nothing moves between bit ticks
    a_r10_hold_mid_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(out_q));
    // R4, R5: the chain head never also signals a collision
    a_r4_r5_head_not_col: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_q.ack_oe && out_q.col_oe));
    // R6: external mode leaves the open-drain lines alone
    a_r6_ext_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        !internal |=> (!out_q.ack_oe && !out_q.col_oe));
    // R7: a driving device also reports itself active downstream
    a_r7_drive_implies_sel: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.bus_oe |-> !out_q.sel_out_n);
    // R8: never drive and receive the pair at once
    a_r8_rx_or_tx: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_q.rx_valid && out_q.bus_oe));
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter
    import xbus_pkg::*;
#(
    parameter int NSEL        = 2,
    parameter int CLK_PER_BIT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSEL-1:0] sel_in_n,
    input  logic            local_active,
    input  logic            local_col,
    input  logic            local_multi,
    input  logic            tx_bit,
    input  logic            ack_n_in,
    input  logic            col_n_in,
    input  logic            jam_in,
    input  logic            dat_in,
    output logic            sel_out_n,
    output logic            ack_oe,
    output logic            col_oe,
    output logic            bus_oe,
    output logic            jam_out,
    output logic            dat_out,
    output logic            rx_valid,
    output logic            rx_jam,
    output logic            rx_dat,
    output logic            coll_seen,
    output logic            arb_internal
);
    bus_smp_t        raw;
    bus_smp_t        smp;
    bus_out_t        out;
    logic [NSEL-1:0] sel_s;
    logic            tick;
    logic            internal;

    assign raw = '{active: local_active, col: local_col, multi: local_multi,
                   txd: tx_bit, ack_n: ack_n_in, col_n: col_n_in,
                   jam: jam_in, dat: dat_in};

    xbus_bit_timer #(.CLK_PER_BIT(CLK_PER_BIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    xbus_strap u_strap (
        .clk(clk), .rst_n(rst_n), .strap_pin(sel_in_n[0]), .internal(internal));

    xbus_sampler #(.NSEL(NSEL)) u_smp (
        .clk(clk), .rst_n(rst_n), .sel_in_n(sel_in_n), .raw(raw),
        .sel_s(sel_s), .smp(smp));

    xbus_ctrl #(.NSEL(NSEL)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .internal(internal),
        .sel_s(sel_s), .smp(smp), .out(out));

    assign sel_out_n    = out.sel_out_n;
    assign ack_oe       = out.ack_oe;
    assign col_oe       = out.col_oe;
    assign bus_oe       = out.bus_oe;
    assign jam_out      = out.jam_out;
    assign dat_out      = out.dat_out;
    assign rx_valid     = out.rx_valid;
    assign rx_jam       = out.rx_jam;
    assign rx_dat       = out.rx_dat;
    assign coll_seen    = out.coll_seen;
    assign arb_internal = internal;
endmodule

// File: tb/xbus_arbiter_tb.sv
module xbus_arbiter_tb_top;
    localparam int CLK_PERIOD = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_in_n = 2'b11;
    logic       local_active = 0, local_col = 0, local_multi = 0, tx_bit = 0;
    logic       ext_ack = 0, ext_col = 0, ext_jam = 0, ext_dat = 0;
    logic       ack_n_in, col_n_in, jam_in, dat_in;
    logic       sel_out_n, ack_oe, col_oe, bus_oe, jam_out, dat_out;
    logic       rx_valid, rx_jam, rx_dat, coll_seen, arb_internal;

    int n_vec = 0;
    int n_bad = 0;

    // expected outputs (previous bit) and mode
    logic e_sel = 1, e_ack = 0, e_col = 0, e_bus = 0, e_jam = 0, e_dat = 0;
    logic e_rxv = 0, e_rxj = 0, e_rxd = 0, e_cs = 0, e_mode = 1;

    // wired lines: other devices modelled by ext_* pulls
    assign ack_n_in = !(ack_oe || ext_ack);
    assign col_n_in = !(col_oe || ext_col);
    assign jam_in   = bus_oe ? jam_out : ext_jam;
    assign dat_in   = bus_oe ? dat_out : ext_dat;

    xbus_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .sel_in_n(sel_in_n),
        .local_active(local_active), .local_col(local_col),
        .local_multi(local_multi), .tx_bit(tx_bit),
        .ack_n_in(ack_n_in), .col_n_in(col_n_in), .jam_in(jam_in), .dat_in(dat_in),
        .sel_out_n(sel_out_n), .ack_oe(ack_oe), .col_oe(col_oe), .bus_oe(bus_oe),
        .jam_out(jam_out), .dat_out(dat_out), .rx_valid(rx_valid),
        .rx_jam(rx_jam), .rx_dat(rx_dat), .coll_seen(coll_seen),
        .arb_internal(arb_internal));

    always #(CLK_PERIOD / 2) clk = !clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, nm, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, "/R3R6"}, "sel_out_n", sel_out_n, e_sel);
        chk({tag, "/R4"}, "ack_oe", ack_oe, e_ack);
        chk({tag, "/R5"}, "col_oe", col_oe, e_col);
        chk({tag, "/R7"}, "bus_oe", bus_oe, e_bus);
        chk({tag, "/R7"}, "jam_out", jam_out, e_jam);
        chk({tag, "/R7"}, "dat_out", dat_out, e_dat);
        chk({tag, "/R8"}, "rx_valid", rx_valid, e_rxv);
        chk({tag, "/R8"}, "rx_jam", rx_jam, e_rxj);
        chk({tag, "/R8"}, "rx_dat", rx_dat, e_rxd);
        chk({tag, "/R9"}, "coll_seen", coll_seen, e_cs);
        chk({tag, "/R2"}, "arb_internal", arb_internal, e_mode);
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0;
        sel_in_n = {1'b1, strap};
        {local_active, local_col, local_multi, tx_bit} = '0;
        {ext_ack, ext_col, ext_jam, ext_dat} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        {e_sel, e_ack, e_col, e_bus, e_jam, e_dat} = 6'b100000;
        {e_rxv, e_rxj, e_rxd, e_cs} = '0;
        e_mode = 1'b1;
        chk_all("R1 reset");
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        e_mode = strap;
        chk_all("R1 after strap");
    endtask

    // apply one bit: drive, check mid-bit hold, check updated outputs
    task automatic bit_vec(input logic [1:0] si, input logic a, input logic c,
                           input logic m, input logic t, input logic [3:0] ext);
        logic ackl, colll, jl, dl, anyl, bothl;
        sel_in_n = si;
        local_active = a; local_col = c; local_multi = m; tx_bit = t;
        {ext_ack, ext_col, ext_jam, ext_dat} = ext;
        ackl  = e_ack || ext[3];
        colll = e_col || ext[2];
        jl    = e_bus ? e_jam : ext[1];
        dl    = e_bus ? e_dat : ext[0];
        anyl  = !si[0] || !si[1];
        bothl = !si[0] && !si[1];
        @(posedge clk);
        @(negedge clk);
        chk_all("R10 mid-bit");
        @(posedge clk);
        @(negedge clk);
        if (e_mode) begin
            e_sel = !(a || anyl);
            e_ack = a && !anyl;
            e_col = (a && anyl) || bothl;
        end else begin
            e_sel = !a;
            e_ack = 1'b0;
            e_col = 1'b0;
        end
        e_bus = a && ackl;
        e_jam = e_bus && c;
        e_dat = e_bus && (c ? !m : t);
        e_rxv = ackl && !a;
        e_rxj = e_rxv && jl;
        e_rxd = e_rxv && dl;
        e_cs  = colll;
        chk_all("R10 tick");
    endtask

    initial begin
        int unsigned lfsr;
        lfsr = 32'hACE1_1234;
        do_reset(1'b1);
        // directed: head device alone, then it drives the pair
        bit_vec(2'b11, 1, 0, 0, 1, 4'b0000);   // R4 ack
        bit_vec(2'b11, 1, 0, 0, 1, 4'b0000);   // R7 data bit 1
        bit_vec(2'b11, 1, 1, 0, 0, 4'b0000);   // R7 single-port collision
        bit_vec(2'b11, 1, 1, 1, 1, 4'b0000);   // R7 multiport collision
        bit_vec(2'b10, 1, 0, 0, 0, 4'b0000);   // R5 active with upstream
        bit_vec(2'b00, 0, 0, 0, 0, 4'b0000);   // R5 two upstream branches
        bit_vec(2'b01, 0, 0, 0, 0, 4'b1011);   // R3 pass-through, R8 receive
        bit_vec(2'b11, 0, 0, 0, 0, 4'b1110);   // R8, R9
        for (int i = 0; i < 60; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            bit_vec(lfsr[1:0], lfsr[2], lfsr[3], lfsr[4], lfsr[5], lfsr[9:6]);
        end
        do_reset(1'b0);
        // R6: select inputs ignored in external mode
        bit_vec(2'b00, 1, 0, 0, 1, 4'b1000);
        bit_vec(2'b11, 1, 1, 1, 0, 4'b1000);
        bit_vec(2'b10, 0, 0, 0, 0, 4'b1111);
        for (int i = 0; i < 40; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            bit_vec(lfsr[1:0], lfsr[2], lfsr[3], lfsr[4], lfsr[5], lfsr[9:6]);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule